// File: doc/BRIEF.md
# Lockstep Column-Parallel Matrix Multiplier

This block multiplies two square matrices of unsigned integers, C = A x B, on a row of N processing elements that all run the same step in the same cycle. Each element owns local storage for one column: element j keeps column j of A, column j of B and column j of C. A whole row of any matrix is therefore spread across the elements, and all of it can be reached in one cycle.

A host first writes the elements of A and B one at a time through a load port, then pulses `start`. For each output row i the controller clears every element's accumulator, then steps k from 0 to N-1. On each step it takes a_ik from element k and broadcasts it, and every element j adds a_ik * b_kj to its accumulator in that same cycle. A final step stores the accumulators as row i of C. One row costs N+2 cycles, so the whole product takes N*(N+2) cycles instead of the N^3 steps of a serial loop nest. When the product is complete, `done` pulses and C can be read back through a registered read port.

Top module: `simd_matmul`

## Requirements
- R1: With `start` pulsed while idle, every stored result satisfies C[i][j] = sum over k of A[i][k]*B[k][j]. The arithmetic is unsigned, and the result width 2W+clog2(N) holds the largest possible sum without wrapping.
- R2: While idle, a cycle with `ld_en` high stores `ld_data` as element (row `ld_row`, column `ld_col`) of A when `ld_sel` is 0, or of B when `ld_sel` is 1.
- R3: A `start` sampled high while idle makes `busy` high from the next cycle for exactly N*(N+2) cycles.
- R4: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low after a run, which follows the edge that writes the last row of C.
- R5: A `rd_en` sampled high while idle places C[`rd_row`][`rd_col`] on `rd_data` in the next cycle, with `rd_err` low. `rd_data` holds its value when `rd_en` is low.
- R6: A `rd_en` sampled high while `busy` is high makes `rd_err` high for the next cycle and `rd_data` zero.
- R7: Loads presented while `busy` is high are ignored, and the product of the current run and of later runs is unchanged by them.
- R8: A `start` sampled while `busy` is high is ignored, and the run in progress keeps its length of N*(N+2) busy cycles.
- R9: After reset, `busy`, `done`, `rd_err` and `rd_data` are zero, and every element of C reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one matrix element |
| ld_sel | input | 1 | Target of the write: 0 selects A, 1 selects B |
| ld_row | input | clog2(N) | Row index of the written element |
| ld_col | input | clog2(N) | Column index, which is also the owning element |
| ld_data | input | W | Value written |
| start | input | 1 | Begin a multiplication |
| rd_en | input | 1 | Read one element of C |
| rd_row | input | clog2(N) | Row index of the read |
| rd_col | input | clog2(N) | Column index of the read |
| rd_data | output | 2W+clog2(N) | Registered read value |
| rd_err | output | 1 | The last read was made while busy |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The assertions assume that reset is held low for some cycles before operation. The timing checks also assume that `start` is a clean strobe: a new run can only begin from idle, so the busy-length counter never sees two runs merge. The bench raises every strobe for one cycle only, changes inputs on the falling edge, and keeps indices inside 0..N-1. It deliberately pulses `start`, a load and a read in the middle of a run, which exercises the ignore and error paths without breaking these assumptions.

// File: rtl/simd_matmul.sv
module simd_matmul #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = 2 * W + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [IW-1:0] ld_row,
  input  logic [IW-1:0] ld_col,
  input  logic [W-1:0]  ld_data,
  input  logic          start,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_row,
  input  logic [IW-1:0] rd_col,
  output logic [AW-1:0] rd_data,
  output logic          rd_err,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_MAC, S_WRITE} state_t;

  state_t        st;
  logic [IW-1:0] row_q, k_q;
  logic          last_k, last_row, ld_ok;
  logic [W-1:0]  a_out [N];
  logic [AW-1:0] c_out [N];
  logic [W-1:0]  a_bc;

  assign busy     = (st != S_IDLE);
  assign last_k   = (k_q == IW'(N - 1));
  assign last_row = (row_q == IW'(N - 1));
  assign ld_ok    = ld_en && !busy;
  assign a_bc     = a_out[k_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      row_q <= '0;
      k_q   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            row_q <= '0;
            st    <= S_INIT;
          end
        S_INIT: begin
          k_q <= '0;
          st  <= S_MAC;
        end
        S_MAC:
          if (last_k) st <= S_WRITE;
          else        k_q <= k_q + 1'b1;
        S_WRITE:
          if (last_row) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
            st    <= S_INIT;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_pe
    logic [W-1:0]   am [N];
    logic [W-1:0]   bm [N];
    logic [AW-1:0]  cm [N];
    logic [AW-1:0]  acc;
    logic [2*W-1:0] prod;

    assign prod     = {{W{1'b0}}, a_bc} * {{W{1'b0}}, bm[k_q]};
    assign a_out[j] = am[row_q];
    assign c_out[j] = cm[rd_row];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < N; r++) begin
          am[r] <= '0;
          bm[r] <= '0;
          cm[r] <= '0;
        end
        acc <= '0;
      end else begin
        if (ld_ok && ld_col == IW'(j)) begin
          if (ld_sel) bm[ld_row] <= ld_data;
          else        am[ld_row] <= ld_data;
        end
        case (st)
          S_INIT:  acc <= '0;
          S_MAC:   acc <= acc + {{(AW-2*W){1'b0}}, prod};
          S_WRITE: cm[row_q] <= acc;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_err <= rd_en && busy;
      if (rd_en) rd_data <= busy ? '0 : c_out[rd_col];
    end
  end

endmodule

// File: rtl/simd_matmul_chk.sv
module simd_matmul_chk #(
  parameter int N  = 4,
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_en,
  input logic [AW-1:0] rd_data,
  input logic          rd_err,
  input logic          busy,
  input logic          done
);

  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else        busy_cnt <= busy ? busy_cnt + 1 : 0;
  end

  a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == N * (N + 2)));

  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(rd_en && busy));

  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0));

endmodule

bind simd_matmul simd_matmul_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
  .rd_data(rd_data), .rd_err(rd_err), .busy(busy), .done(done)
);

// File: tb/test_simd_matmul.sv
`timescale 1ns/100ps
module test_simd_matmul;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int IW = $clog2(N);
  localparam int AW = 2 * W + IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0, rd_en = 1'b0;
  logic [IW-1:0] ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
  logic [W-1:0]  ld_data = '0;
  logic [AW-1:0] rd_data;
  logic          rd_err, busy, done;

  int ma [N][N];
  int mb [N][N];
  int mc [N][N];
  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  simd_matmul #(.N(N), .W(W)) i_simd_matmul (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .rd_err(rd_err), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mc[i][j] = 0;
        for (int k = 0; k < N; k++) mc[i][j] += ma[i][k] * mb[k][j];
      end
  endtask

  task automatic load_all();
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          @(negedge clk);
          ld_en = 1'b1; ld_sel = s[0]; ld_row = IW'(r); ld_col = IW'(c);
          ld_data = W'(s == 0 ? ma[r][c] : mb[r][c]);
        end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        rd_en = 1'b1; rd_row = IW'(r); rd_col = IW'(c);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == AW'(mc[r][c]), tag, rd_data, mc[r][c]);
        chk(rd_err == 1'b0, "R5 rd_err idle", rd_err, 0);
      end
    @(negedge clk);
    chk(rd_data == AW'(mc[N-1][N-1]), "R5 hold", rd_data, mc[N-1][N-1]);
  endtask

  task automatic run(input bit disturb);
    int cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (disturb && cnt == 3) begin
        ld_en = 1'b1; ld_sel = 1'b0; ld_row = '0; ld_col = '0; ld_data = 8'hAB;
        start = 1'b1; rd_en = 1'b1; rd_row = '0; rd_col = '0;
      end else if (disturb && cnt == 4) begin
        ld_en = 1'b0; start = 1'b0; rd_en = 1'b0;
        chk(rd_err == 1'b1, "R6 rd_err busy", rd_err, 1);
        chk(rd_data == '0, "R6 rd_data busy", rd_data, 0);
      end
      @(negedge clk);
    end
    chk(cnt == N * (N + 2), disturb ? "R8 busy length" : "R3 busy length", cnt, N * (N + 2));
    chk(done == 1'b1, "R4 done rises", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single", done, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(done == 1'b0, "R9 done", done, 0);
    chk(rd_err == 1'b0, "R9 rd_err", rd_err, 0);
    chk(rd_data == '0, "R9 rd_data", rd_data, 0);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mc[i][j] = 0;
    read_all("R9 C zero");
  endtask

  task automatic t_identity();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = 10 * i + j + 1;
      end
    model(); load_all(); run(1'b0);
    read_all("R2 identity");
  endtask

  task automatic t_random(input int reps);
    for (int t = 0; t < reps; t++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          ma[i][j] = int'($urandom_range(255, 0));
          mb[i][j] = int'($urandom_range(255, 0));
        end
      model(); load_all(); run(1'b0);
      read_all("R1 random");
    end
  endtask

  task automatic t_max();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 255;
        mb[i][j] = 255;
      end
    model(); load_all(); run(1'b0);
    read_all("R1 max no overflow");
  endtask

  task automatic t_disturb();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = i + 2 * j + 1;
        mb[i][j] = 3 * i + j;
      end
    model(); load_all(); run(1'b1);
    read_all("R7 load ignored");
    run(1'b0);
    read_all("R7 rerun unchanged");
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_random(3);
    t_max();
    t_disturb();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule